// File: doc/BRIEF.md
# Segment Register Load Checker

This block services one request at a time to place a 16-bit selector into a segment register. The request names a register slot: slot 0 is the stack segment and every other slot is a data segment. Alongside the selector come the current operating mode (real, virtual-8086, protected or 64-bit) and the current privilege level. In real and virtual-8086 modes the block fills the slot's cached descriptor directly from the selector. In protected and 64-bit modes it fetches the 8-byte descriptor over a fetch port, decodes it, and runs the privilege and type rules in a fixed order. After that it either commits the new cache contents or reports a single fault with its class and error code.

When a protected-mode load succeeds on a descriptor whose accessed type bit is clear, the block issues a 1-byte write that sets that bit in the descriptor table, and it waits for that write before it commits. All slots are held inside the block. A combinational read port shows any slot's cached contents to the surrounding pipeline.

Top module: `seg_load_unit`

## Requirements
- R1: In protected or 64-bit mode, a data-slot request whose selector has bits 15:2 all zero completes with no fault and no fetch. The slot keeps the selector and its low two bits as requested privilege, and it is marked invalid with base 0, limit 0, AR byte 0x10, G 0 and D/B 0.
- R2: A null selector for the stack slot raises a general-protection fault with error code 0 and leaves the slot unchanged. The one exception is 64-bit mode with privilege level other than 3 and requested privilege equal to it, where the load proceeds as in R1.
- R3: For the stack slot the rules fire in this order: requested privilege equals current privilege; descriptor valid; writable data segment; descriptor privilege equals current privilege; present. The first failing rule decides the fault. The first four raise general-protection (code 1) and the last raises stack fault (code 2).
- R4: For a data slot the descriptor must be code/data (AR bit 4 set) and either data (type bit 3 clear) or readable code (type bits 3 and 1 set), otherwise general-protection.
- R5: For a data slot holding data or non-conforming code (type bit 2 clear), a requested privilege or current privilege above the descriptor privilege raises general-protection. Conforming code is exempt.
- R6: A data-slot descriptor that passes R4 and R5 but has the present bit (AR bit 7) clear raises segment-not-present (code 3). If it also fails R5, general-protection wins.
- R7: Every fault reports the selector with bits 1:0 cleared as error code, and it leaves the slot's cached contents untouched.
- R8: The descriptor fetch address is the table base (local table when selector bit 2 is set, global otherwise) plus selector bits 15:3 times 8. Descriptor layout: limit = {bits 51:48, 15:0}; base = {bits 63:56, 39:32, 31:16}; AR byte = bits 47:40 ordered {P, DPL[1:0], S, TYPE[3:0]}; D/B = bit 54; G = bit 55.
- R9: A successful protected load stores the selector, requested privilege = selector bits 1:0, valid = 1, the base, the AR byte with type bit 0 set, G, D/B, and the limit. The limit is scaled as {limit, 12'hFFF} when G is 1 and taken as-is otherwise.
- R10: When the fetched type bit 0 is clear, a successful load issues one write to fetch address + 5 carrying the AR byte with bit 0 set. When it is already set, no write occurs.
- R11: After reset every slot holds selector 0, requested privilege 0, valid, base 0, limit 0xFFFF, AR 0x93, G 0, D/B 0. A real-mode load sets selector, base = selector × 16, requested privilege 0, valid, P 1, S 1, and keeps limit, type, DPL, G and D/B as they were.
- R12: A virtual-8086 load sets selector, base = selector × 16, requested privilege 3, valid, AR 0xF3, limit 0xFFFF, G 0, D/B 0.
- R13: Requests are accepted only while idle. done_valid is a one-cycle pulse. Loads that need no fetch finish in the cycle after acceptance. A fetched load finishes two cycles after the cycle in which the response is taken, or three cycles if the accessed write is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_slot | input | 2 | Target slot, 0 = stack segment |
| req_sel | input | 16 | Selector to load |
| mode | input | 2 | 0 real, 1 virtual-8086, 2 protected, 3 64-bit |
| cpl | input | 2 | Current privilege level |
| gdt_base | input | 32 | Global descriptor table base |
| ldt_base | input | 32 | Local descriptor table base |
| fd_req_valid | output | 1 | Descriptor fetch request |
| fd_req_ready | input | 1 | Fetch request accepted |
| fd_req_addr | output | 32 | Descriptor address |
| fd_rsp_valid | input | 1 | Descriptor data present |
| fd_rsp_data | input | 64 | Raw 8-byte descriptor |
| acc_wr_valid | output | 1 | Accessed-bit write request |
| acc_wr_ready | input | 1 | Accessed-bit write accepted |
| acc_wr_addr | output | 32 | Byte address of the AR byte |
| acc_wr_data | output | 8 | AR byte with accessed bit set |
| done_valid | output | 1 | Request finished (one cycle) |
| done_fault | output | 2 | 0 none, 1 general-protection, 2 stack, 3 not-present |
| done_err | output | 16 | Fault error code |
| rd_slot | input | 2 | Slot shown on the read port |
| rd_sel | output | 16 | Slot selector |
| rd_rpl | output | 2 | Slot requested privilege |
| rd_valid | output | 1 | Slot cache valid |
| rd_base | output | 32 | Slot base |
| rd_limit | output | 32 | Slot scaled limit |
| rd_ar | output | 8 | Slot AR byte {P, DPL, S, TYPE} |
| rd_g | output | 1 | Slot granularity |
| rd_db | output | 1 | Slot default size |

## Verification
Real-mode, virtual-8086 and null loads must raise done_valid at the first falling edge after the accepting rising edge. The bench answers a fetch request one cycle after it sees it. With that response timing, a fetched load must be done at the fourth falling edge after acceptance, or the fifth when an accessed write is accepted first. The bench counts falling edges from acceptance and compares that count with the value its own model predicts for each request. The read port is sampled only after done_valid, when the commit edge has passed. The fetch and write addresses are recorded when those strobes appear and are compared afterwards.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        MODE_REAL = 2'd0,
        MODE_V86  = 2'd1,
        MODE_PROT = 2'd2,
        MODE_LONG = 2'd3
    } cpu_mode_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_SS   = 2'd2,
        FLT_NP   = 2'd3
    } fault_e;

    typedef struct packed {
        logic       p;
        logic [1:0] dpl;
        logic       s;
        logic [3:0] typ;
    } ar_t;

    typedef struct packed {
        logic [31:0] base;
        logic [31:0] limit;
        ar_t         ar;
        logic        g;
        logic        db;
        logic        valid;
    } desc_t;

    typedef struct packed {
        logic [15:0] sel;
        logic [1:0]  rpl;
        desc_t       d;
    } seg_cache_t;

    localparam seg_cache_t CACHE_RST = '{
        sel: 16'h0000, rpl: 2'd0,
        d: '{base: 32'h0, limit: 32'h0000_FFFF,
             ar: '{p: 1'b1, dpl: 2'd0, s: 1'b1, typ: 4'h3},
             g: 1'b0, db: 1'b0, valid: 1'b1}};

    function automatic logic sel_is_null(input logic [15:0] s);
        return (s[15:2] == 14'd0);
    endfunction

    function automatic logic [15:0] sel_err_code(input logic [15:0] s);
        return {s[15:2], 2'b00};
    endfunction

    // system descriptor types that decode to something; the rest are reserved
    function automatic logic sys_type_known(input logic [3:0] t);
        return !(t == 4'h0 || t == 4'h8 || t == 4'hA || t == 4'hD);
    endfunction

endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_pkg::*;
(
    input  logic [63:0] raw,
    output desc_t       dec
);
    logic [19:0] lim_raw;
    logic        unused_bits;

    assign lim_raw     = {raw[51:48], raw[15:0]};
    assign unused_bits = ^raw[53:52];

    always_comb begin
        dec.ar    = ar_t'(raw[47:40]);
        dec.base  = {raw[63:56], raw[39:32], raw[31:16]};
        dec.g     = raw[55];
        dec.db    = raw[54];
        dec.limit = raw[55] ? {lim_raw, 12'hFFF} : {12'h000, lim_raw};
        dec.valid = raw[44] ? 1'b1 : sys_type_known(raw[43:40]);
    end
endmodule

// File: rtl/seg_rule_check.sv
module seg_rule_check
    import seg_pkg::*;
(
    input  desc_t      d,
    input  logic       is_stack,
    input  logic [1:0] rpl,
    input  logic [1:0] cpl,
    output fault_e     fault
);
    logic is_code, rw_bit, conf_bit;

    assign is_code  = d.ar.typ[3];
    assign rw_bit   = d.ar.typ[1];
    assign conf_bit = d.ar.typ[2];

    always_comb begin
        fault = FLT_NONE;
        if (is_stack) begin
            if (rpl != cpl)                        fault = FLT_GP;
            else if (!d.valid)                     fault = FLT_GP;
            else if (!d.ar.s || is_code || !rw_bit) fault = FLT_GP;
            else if (d.ar.dpl != cpl)              fault = FLT_GP;
            else if (!d.ar.p)                      fault = FLT_SS;
        end else begin
            if (!d.valid)                          fault = FLT_GP;
            else if (!d.ar.s || (is_code && !rw_bit)) fault = FLT_GP;
            else if ((!is_code || !conf_bit) &&
                     ((rpl > d.ar.dpl) || (cpl > d.ar.dpl)))
                                                   fault = FLT_GP;
            else if (!d.ar.p)                      fault = FLT_NP;
        end
    end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
    import seg_pkg::*;
#(
    parameter int NSEG   = 4,
    parameter int ADDR_W = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [$clog2(NSEG)-1:0] req_slot,
    input  logic [15:0]             req_sel,
    input  logic [1:0]              mode,
    input  logic [1:0]              cpl,
    input  logic [ADDR_W-1:0]       gdt_base,
    input  logic [ADDR_W-1:0]       ldt_base,
    output logic                    fd_req_valid,
    input  logic                    fd_req_ready,
    output logic [ADDR_W-1:0]       fd_req_addr,
    input  logic                    fd_rsp_valid,
    input  logic [63:0]             fd_rsp_data,
    output logic                    acc_wr_valid,
    input  logic                    acc_wr_ready,
    output logic [ADDR_W-1:0]       acc_wr_addr,
    output logic [7:0]              acc_wr_data,
    output logic                    done_valid,
    output logic [1:0]              done_fault,
    output logic [15:0]             done_err,
    input  logic [$clog2(NSEG)-1:0] rd_slot,
    output logic [15:0]             rd_sel,
    output logic [1:0]              rd_rpl,
    output logic                    rd_valid,
    output logic [31:0]             rd_base,
    output logic [31:0]             rd_limit,
    output logic [7:0]              rd_ar,
    output logic                    rd_g,
    output logic                    rd_db
);
    localparam int IDX_W = $clog2(NSEG);

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_WAIT, ST_CHECK, ST_ACC, ST_DONE
    } state_e;

    state_e                state, nstate;
    seg_cache_t [NSEG-1:0] cache_q;
    logic [IDX_W-1:0]      slot_q;
    logic [15:0]           sel_q;
    logic [1:0]            cpl_q;
    logic [63:0]           raw_q;
    logic [ADDR_W-1:0]     faddr_q;
    fault_e                fault_q, nfault;
    logic [15:0]           err_q, nerr;

    logic                  wr_en, ld_req, ld_raw;
    logic [IDX_W-1:0]      wr_idx;
    seg_cache_t            wr_data, cur, rm_entry, null_entry, pm_entry;
    desc_t                 dec;
    fault_e                chk_fault;
    cpu_mode_e             mode_e;
    logic                  null_ss_ok;
    logic [ADDR_W-1:0]     faddr_n;

    assign mode_e = cpu_mode_e'(mode);

    seg_desc_decode u_dec (.raw(raw_q), .dec(dec));

    seg_rule_check u_chk (
        .d(dec), .is_stack(slot_q == '0), .rpl(sel_q[1:0]),
        .cpl(cpl_q), .fault(chk_fault)
    );

    // entry builders for the three commit paths
    always_comb begin
        cur = cache_q[req_slot];

        rm_entry            = cur;
        rm_entry.sel        = req_sel;
        rm_entry.rpl        = (mode_e == MODE_V86) ? 2'd3 : 2'd0;
        rm_entry.d.valid    = 1'b1;
        rm_entry.d.base     = {12'h000, req_sel, 4'h0};
        rm_entry.d.ar.s     = 1'b1;
        rm_entry.d.ar.p     = 1'b1;
        if (mode_e == MODE_V86) begin
            rm_entry.d.ar.typ = 4'h3;
            rm_entry.d.ar.dpl = 2'd3;
            rm_entry.d.limit  = 32'h0000_FFFF;
            rm_entry.d.g      = 1'b0;
            rm_entry.d.db     = 1'b0;
        end

        null_entry          = '0;
        null_entry.sel      = req_sel;
        null_entry.rpl      = req_sel[1:0];
        null_entry.d.ar.s   = 1'b1;

        pm_entry            = '{sel: sel_q, rpl: sel_q[1:0], d: dec};
        pm_entry.d.valid    = 1'b1;
        pm_entry.d.ar.typ[0] = 1'b1;
    end

    assign null_ss_ok = (mode_e == MODE_LONG) && (cpl != 2'd3) && (req_sel[1:0] == cpl);
    assign faddr_n    = (req_sel[2] ? ldt_base : gdt_base)
                      + {{(ADDR_W-16){1'b0}}, req_sel[15:3], 3'b000};

    always_comb begin
        nstate  = state;
        wr_en   = 1'b0;
        wr_idx  = slot_q;
        wr_data = pm_entry;
        ld_req  = 1'b0;
        ld_raw  = 1'b0;
        nfault  = FLT_NONE;
        nerr    = '0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                ld_req = 1'b1;
                wr_idx = req_slot;
                if (mode_e == MODE_REAL || mode_e == MODE_V86) begin
                    wr_en   = 1'b1;
                    wr_data = rm_entry;
                    nstate  = ST_DONE;
                end else if (sel_is_null(req_sel)) begin
                    if (req_slot != '0 || null_ss_ok) begin
                        wr_en   = 1'b1;
                        wr_data = null_entry;
                    end else begin
                        nfault = FLT_GP;
                        nerr   = sel_err_code(req_sel);
                    end
                    nstate = ST_DONE;
                end else begin
                    nstate = ST_FETCH;
                end
            end
            ST_FETCH: if (fd_req_ready) nstate = ST_WAIT;
            ST_WAIT: if (fd_rsp_valid) begin
                ld_raw = 1'b1;
                nstate = ST_CHECK;
            end
            ST_CHECK: begin
                if (chk_fault != FLT_NONE) begin
                    nfault = chk_fault;
                    nerr   = sel_err_code(sel_q);
                    nstate = ST_DONE;
                end else if (!dec.ar.typ[0]) begin
                    nstate = ST_ACC;
                end else begin
                    wr_en  = 1'b1;
                    nstate = ST_DONE;
                end
            end
            ST_ACC: if (acc_wr_ready) begin
                wr_en  = 1'b1;
                nstate = ST_DONE;
            end
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            slot_q  <= '0;
            sel_q   <= '0;
            cpl_q   <= '0;
            raw_q   <= '0;
            faddr_q <= '0;
            fault_q <= FLT_NONE;
            err_q   <= '0;
        end else begin
            state <= nstate;
            if (ld_req) begin
                slot_q  <= req_slot;
                sel_q   <= req_sel;
                cpl_q   <= cpl;
                faddr_q <= faddr_n;
            end
            if (ld_raw) raw_q <= fd_rsp_data;
            if (nstate == ST_DONE && state != ST_DONE) begin
                fault_q <= nfault;
                err_q   <= nerr;
            end
        end
    end

    for (genvar i = 0; i < NSEG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                cache_q[i] <= CACHE_RST;
            else if (wr_en && wr_idx == IDX_W'(i))  cache_q[i] <= wr_data;
        end
    end

    assign req_ready    = (state == ST_IDLE);
    assign fd_req_valid = (state == ST_FETCH);
    assign fd_req_addr  = faddr_q;
    assign acc_wr_valid = (state == ST_ACC);
    assign acc_wr_addr  = faddr_q + ADDR_W'(5);
    assign acc_wr_data  = {dec.ar.p, dec.ar.dpl, dec.ar.s, dec.ar.typ[3:1], 1'b1};
    assign done_valid   = (state == ST_DONE);
    assign done_fault   = fault_q;
    assign done_err     = err_q;

    assign rd_sel   = cache_q[rd_slot].sel;
    assign rd_rpl   = cache_q[rd_slot].rpl;
    assign rd_valid = cache_q[rd_slot].d.valid;
    assign rd_base  = cache_q[rd_slot].d.base;
    assign rd_limit = cache_q[rd_slot].d.limit;
    assign rd_ar    = cache_q[rd_slot].d.ar;
    assign rd_g     = cache_q[rd_slot].d.g;
    assign rd_db    = cache_q[rd_slot].d.db;

    p_fetch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        fd_req_valid && !fd_req_ready |=> fd_req_valid && $stable(fd_req_addr));

    p_acc_then_ok_r10: assert property (@(posedge clk) disable iff (rst)
        acc_wr_valid && acc_wr_ready |=> done_valid && done_fault == FLT_NONE);

    p_fault_keeps_cache_r7: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault != FLT_NONE |-> $stable(cache_q));

    p_err_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> done_err[1:0] == 2'b00);

    p_stack_fault_slot_r3: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault == FLT_SS |-> slot_q == '0);

    p_np_fault_slot_r6: assert property (@(posedge clk) disable iff (rst)
        done_valid && done_fault == FLT_NP |-> slot_q != '0);

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !done_valid && req_ready);
endmodule

// File: tb/seg_load_unit_tb.sv
module seg_load_unit_tb;
    import seg_pkg::*;

    localparam logic [31:0] GDT = 32'h0010_0000;
    localparam logic [31:0] LDT = 32'h0020_4000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_slot = '0;
    logic [15:0] req_sel = '0;
    logic [1:0]  mode = '0, cpl = '0;
    logic        fd_req_valid, fd_req_ready = 1'b1;
    logic [31:0] fd_req_addr;
    logic        fd_rsp_valid = 1'b0;
    logic [63:0] fd_rsp_data = '0;
    logic        acc_wr_valid, acc_wr_ready = 1'b1;
    logic [31:0] acc_wr_addr;
    logic [7:0]  acc_wr_data;
    logic        done_valid;
    logic [1:0]  done_fault;
    logic [15:0] done_err;
    logic [1:0]  rd_slot = '0;
    logic [15:0] rd_sel;
    logic [1:0]  rd_rpl;
    logic        rd_valid;
    logic [31:0] rd_base, rd_limit;
    logic [7:0]  rd_ar;
    logic        rd_g, rd_db;

    int n_chk = 0, n_err = 0;
    bit finished = 0;
    seg_cache_t mdl [4];

    always #5 clk = ~clk;

    seg_load_unit u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_slot(req_slot), .req_sel(req_sel), .mode(mode), .cpl(cpl),
        .gdt_base(GDT), .ldt_base(LDT),
        .fd_req_valid(fd_req_valid), .fd_req_ready(fd_req_ready), .fd_req_addr(fd_req_addr),
        .fd_rsp_valid(fd_rsp_valid), .fd_rsp_data(fd_rsp_data),
        .acc_wr_valid(acc_wr_valid), .acc_wr_ready(acc_wr_ready),
        .acc_wr_addr(acc_wr_addr), .acc_wr_data(acc_wr_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_err(done_err),
        .rd_slot(rd_slot), .rd_sel(rd_sel), .rd_rpl(rd_rpl), .rd_valid(rd_valid),
        .rd_base(rd_base), .rd_limit(rd_limit), .rd_ar(rd_ar), .rd_g(rd_g), .rd_db(rd_db)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic [31:0] base, input logic [19:0] lim,
                                            input logic [7:0] ar, input bit g, input bit db);
        return {base[31:24], g, db, 2'b00, lim[19:16], ar, base[23:16], base[15:0], lim[15:0]};
    endfunction

    // reference model written from the requirements
    task automatic model(input int slot, input logic [15:0] sel, input logic [1:0] md,
                         input logic [1:0] cp, input logic [63:0] raw,
                         output logic [1:0] f, output logic [15:0] err,
                         output bit fetch, output bit acc, output seg_cache_t nc);
        logic [7:0] ar;
        logic [19:0] lim;
        bit vld, code, rw, conf, ss;
        nc = mdl[slot]; f = 2'd0; err = 16'h0; fetch = 0; acc = 0;
        ss = (slot == 0);
        if (md == 2'd0 || md == 2'd1) begin
            nc.sel = sel; nc.rpl = (md == 2'd1) ? 2'd3 : 2'd0;
            nc.d.valid = 1; nc.d.base = {12'h0, sel, 4'h0};
            nc.d.ar.p = 1; nc.d.ar.s = 1;
            if (md == 2'd1) begin
                nc.d.ar = 8'hF3; nc.d.limit = 32'hFFFF; nc.d.g = 0; nc.d.db = 0;
            end
            return;
        end
        if (sel[15:2] == 0) begin
            if (!ss || (md == 2'd3 && cp != 2'd3 && sel[1:0] == cp)) begin
                nc = '0; nc.sel = sel; nc.rpl = sel[1:0]; nc.d.ar = 8'h10;
            end else begin
                f = 2'd1; err = 16'h0;
            end
            return;
        end
        fetch = 1;
        ar = raw[47:40]; lim = {raw[51:48], raw[15:0]};
        vld = ar[4] ? 1'b1 : !(ar[3:0] == 0 || ar[3:0] == 8 || ar[3:0] == 10 || ar[3:0] == 13);
        code = ar[3]; rw = ar[1]; conf = ar[2];
        if (ss) begin
            if (sel[1:0] != cp || !vld || !ar[4] || code || !rw || ar[6:5] != cp) f = 2'd1;
            else if (!ar[7]) f = 2'd2;
        end else begin
            if (!vld || !ar[4] || (code && !rw)) f = 2'd1;
            else if ((!code || !conf) && (sel[1:0] > ar[6:5] || cp > ar[6:5])) f = 2'd1;
            else if (!ar[7]) f = 2'd3;
        end
        if (f != 0) begin
            err = {sel[15:2], 2'b00};
            return;
        end
        acc = !ar[0];
        nc.sel = sel; nc.rpl = sel[1:0]; nc.d.valid = 1;
        nc.d.base = {raw[63:56], raw[39:32], raw[31:16]};
        nc.d.g = raw[55]; nc.d.db = raw[54];
        nc.d.limit = raw[55] ? {lim, 12'hFFF} : {12'h0, lim};
        nc.d.ar = ar | 8'h01;
    endtask

    task automatic check_slot(input int slot, input string rq);
        rd_slot = 2'(slot);
        #1;
        chk(rd_sel == mdl[slot].sel, rq, "sel", rd_sel, mdl[slot].sel);
        chk(rd_rpl == mdl[slot].rpl, rq, "rpl", rd_rpl, mdl[slot].rpl);
        chk(rd_valid == mdl[slot].d.valid, rq, "valid", rd_valid, mdl[slot].d.valid);
        chk(rd_base == mdl[slot].d.base, rq, "base", rd_base, mdl[slot].d.base);
        chk(rd_limit == mdl[slot].d.limit, rq, "limit", rd_limit, mdl[slot].d.limit);
        chk(rd_ar == mdl[slot].d.ar, rq, "ar", rd_ar, mdl[slot].d.ar);
        chk({rd_g, rd_db} == {mdl[slot].d.g, mdl[slot].d.db}, rq, "g/db",
            {rd_g, rd_db}, {mdl[slot].d.g, mdl[slot].d.db});
    endtask

    task automatic run_load(input int slot, input logic [15:0] sel, input logic [1:0] md,
                            input logic [1:0] cp, input logic [63:0] raw, input string rq);
        logic [1:0] ef; logic [15:0] ee; bit ef_fetch, ef_acc; seg_cache_t nc;
        bit got = 0, saw_f = 0, saw_a = 0, pend = 0;
        int n, lat = 0, elat;
        logic [31:0] fa = '0, aa = '0, etab;
        logic [7:0] ad = '0;
        logic [1:0] gf = '0; logic [15:0] ge = '0;
        model(slot, sel, md, cp, raw, ef, ee, ef_fetch, ef_acc, nc);
        @(negedge clk);
        chk(req_ready == 1'b1, "R13", "ready when idle", req_ready, 1);
        req_valid = 1; req_slot = 2'(slot); req_sel = sel; mode = md; cpl = cp;
        @(negedge clk);
        req_valid = 0;
        n = 1;
        while (!got && n <= 20) begin
            if (pend) begin fd_rsp_valid = 1; fd_rsp_data = raw; pend = 0; end
            else fd_rsp_valid = 0;
            if (fd_req_valid) begin saw_f = 1; fa = fd_req_addr; pend = 1; end
            if (acc_wr_valid) begin saw_a = 1; aa = acc_wr_addr; ad = acc_wr_data; end
            if (done_valid) begin got = 1; lat = n; gf = done_fault; ge = done_err; end
            else begin @(negedge clk); n++; end
        end
        fd_rsp_valid = 0;
        elat = !ef_fetch ? 1 : ((ef == 0 && ef_acc) ? 5 : 4);
        etab = (sel[2] ? LDT : GDT) + {16'h0, sel[15:3], 3'b000};
        chk(got, "R13", "done seen", got, 1);
        chk(lat == elat, "R13", "latency", lat, elat);
        chk(gf == ef, rq, "fault class", gf, ef);
        chk(ge == ee, "R7", "error code", ge, ee);
        chk(saw_f == ef_fetch, "R8", "fetch issued", saw_f, ef_fetch);
        if (ef_fetch) chk(fa == etab, "R8", "fetch addr", fa, etab);
        chk(saw_a == ef_acc, "R10", "accessed write", saw_a, ef_acc);
        if (ef_acc) begin
            chk(aa == etab + 5, "R10", "acc addr", aa, etab + 5);
            chk(ad == (raw[47:40] | 8'h01), "R10", "acc data", ad, raw[47:40] | 8'h01);
        end
        mdl[slot] = nc;
        check_slot(slot, rq);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4; i++) mdl[i] = CACHE_RST;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) check_slot(i, "R11");

        // real mode on reset slot
        run_load(1, 16'h1234, 2'd0, 2'd0, 64'h0, "R11");
        // protected data load, page-granular limit, accessed clear
        run_load(1, 16'h0010, 2'd2, 2'd0, mk_desc(32'h12AB_0000, 20'h02345, 8'h92, 1, 1), "R9");
        // real mode keeps limit/attributes from previous protected load
        run_load(1, 16'h0040, 2'd0, 2'd2, 64'h0, "R11");
        run_load(1, 16'hF000, 2'd1, 2'd0, 64'h0, "R12");
        run_load(2, 16'h0003, 2'd2, 2'd1, 64'h0, "R1");
        run_load(0, 16'h0000, 2'd2, 2'd0, 64'h0, "R2");
        run_load(0, 16'h0001, 2'd3, 2'd1, 64'h0, "R2");
        run_load(0, 16'h0003, 2'd3, 2'd3, 64'h0, "R2");
        // stack ordering
        run_load(0, 16'h0029, 2'd2, 2'd0, mk_desc(32'h0, 20'hFFFFF, 8'h13, 0, 0), "R3");
        run_load(0, 16'h0028, 2'd2, 2'd0, mk_desc(32'h0, 20'hFFFFF, 8'h13, 0, 0), "R3");
        run_load(0, 16'h0028, 2'd2, 2'd0, mk_desc(32'h0, 20'hFFFFF, 8'h9A, 0, 0), "R3");
        run_load(0, 16'h0028, 2'd2, 2'd0, mk_desc(32'h0, 20'hFFFFF, 8'h91, 0, 0), "R3");
        run_load(0, 16'h0028, 2'd2, 2'd0, mk_desc(32'h0, 20'hFFFFF, 8'hB3, 0, 0), "R3");
        run_load(0, 16'h000E, 2'd2, 2'd2, mk_desc(32'h0800_0000, 20'h0FFFF, 8'hD3, 0, 1), "R10");
        // data slot rules
        run_load(3, 16'h0030, 2'd2, 2'd0, mk_desc(32'h0, 20'h00FFF, 8'h82, 0, 0), "R4");
        run_load(3, 16'h0030, 2'd2, 2'd0, mk_desc(32'h0, 20'h00FFF, 8'h98, 0, 0), "R4");
        run_load(3, 16'h0030, 2'd2, 2'd1, mk_desc(32'h0, 20'h00FFF, 8'h9A, 0, 0), "R5");
        run_load(3, 16'h0033, 2'd2, 2'd3, mk_desc(32'hABCD_0000, 20'h00FFF, 8'h9E, 0, 1), "R5");
        run_load(3, 16'h0033, 2'd2, 2'd0, mk_desc(32'h0, 20'h00FFF, 8'h93, 0, 0), "R5");
        run_load(2, 16'h0038, 2'd3, 2'd0, mk_desc(32'h0, 20'h00FFF, 8'h13, 0, 0), "R6");
        run_load(2, 16'h003B, 2'd3, 2'd0, mk_desc(32'h0, 20'h00FFF, 8'h13, 0, 0), "R6");

        for (int it = 0; it < 400; it++) begin
            int slot; logic [15:0] sel; logic [1:0] md, cp; logic [7:0] ar; logic [63:0] raw;
            int r;
            slot = $urandom % 4;
            r = $urandom % 8;
            md = (r == 0) ? 2'd0 : (r == 1) ? 2'd1 : (r < 5) ? 2'd2 : 2'd3;
            cp = 2'($urandom);
            sel = 16'($urandom);
            if ($urandom % 8 == 0) sel[15:2] = '0;
            if (slot == 0 && ($urandom % 4 != 0)) sel[1:0] = cp;
            ar = 8'($urandom);
            if ($urandom % 4 != 0) ar[4] = 1;
            if ($urandom % 4 != 0) ar[7] = 1;
            if ($urandom % 2 == 0) ar[6:5] = cp;
            raw = mk_desc($urandom, 20'($urandom), ar, 1'($urandom), 1'($urandom));
            run_load(slot, sel, md, cp, raw, "R9");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule